// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, within the same cycle, whether a conditional branch is taken. It has no clock and no reset. It takes an enable from the main instruction decoder and the 3-bit condition field of the instruction. It also takes two flags from the ALU, which computes the first source register minus the second for every branch. The first flag is high when that difference is zero. The second flag is bit 31 of the difference. The block drives a single take signal, and that signal selects the branch target in the program-counter mux.

Four conditions are resolved:

- equal
- not equal
- signed less-than
- signed greater-or-equal

Each is resolved from the two flags alone, using a fixed table. No comparator is used. The unsigned conditions are not supported. Neither is an overflow-corrected signed comparison. Any condition code outside the four supported ones resolves to not-taken.

Internally, a small decoder maps the condition field onto an enumerated condition kind. An evaluator then resolves that kind against the flags. The top gates the evaluator's result with the enable.

Top module: `br_resolve`

## Requirements
- R1: When `br_en` is 0, `take_branch` is 0 for every value of the other inputs.
- R2: With `br_en` = 1 and `cond` = 3'b000 (equal), `take_branch` equals `alu_zero`, whatever `alu_sign` is.
- R3: With `br_en` = 1 and `cond` = 3'b001 (not equal), `take_branch` equals the inverse of `alu_zero`, whatever `alu_sign` is.
- R4: With `br_en` = 1 and `cond` = 3'b100 (signed less-than), `take_branch` is 0 when `alu_zero` is 1, and equals `alu_sign` when `alu_zero` is 0.
- R5: With `br_en` = 1 and `cond` = 3'b101 (signed greater-or-equal), `take_branch` is 1 when `alu_zero` is 1, and equals the inverse of `alu_sign` when `alu_zero` is 0.
- R6: With `br_en` = 1 and `cond` set to any of 3'b010, 3'b011, 3'b110 or 3'b111, `take_branch` is 0.
- R7: The output is a pure function of the current inputs. It settles in the same cycle the inputs change, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_en | input | 1 | Branch enable from the main decoder |
| cond | input | 3 | Condition field of the branch instruction |
| alu_zero | input | 1 | High when rs1 minus rs2 is zero |
| alu_sign | input | 1 | Bit 31 of rs1 minus rs2 |
| take_branch | output | 1 | High when the branch is taken |

## Verification
The bench sweeps every combination of enable, condition code and flags. It also drives flags produced from real operand pairs: equal values, positive and negative differences, and operands either side of zero.

The corner cases are the zero-flag-high rows for less-than and greater-or-equal. Getting these wrong would take the less-than branch on equal operands, or would fall through on a greater-or-equal with equal operands. The bench also checks that equal and not-equal ignore the sign bit, that the four unsupported codes never fire, and that a low enable suppresses every one of them. A design that decoded only the low condition bits would take branches on the unsupported codes.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int COND_W = 3;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_EQ,
        KIND_NE,
        KIND_LT,
        KIND_GE
    } br_kind_e;

    localparam logic [COND_W-1:0] CODE_EQ = 3'b000;
    localparam logic [COND_W-1:0] CODE_NE = 3'b001;
    localparam logic [COND_W-1:0] CODE_LT = 3'b100;
    localparam logic [COND_W-1:0] CODE_GE = 3'b101;
endpackage

// File: rtl/br_kind_decode.sv
module br_kind_decode
    import br_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    output br_kind_e          kind
);
    always_comb begin
        unique case (cond)
            CODE_EQ: kind = KIND_EQ;
            CODE_NE: kind = KIND_NE;
            CODE_LT: kind = KIND_LT;
            CODE_GE: kind = KIND_GE;
            default: kind = KIND_NONE;
        endcase
    end
endmodule

// File: rtl/br_flag_eval.sv
module br_flag_eval
    import br_pkg::*;
(
    input  br_kind_e kind,
    input  logic     alu_zero,
    input  logic     alu_sign,
    output logic     hit
);
    always_comb begin
        unique case (kind)
            KIND_EQ: hit = alu_zero;
            KIND_NE: hit = !alu_zero;
            KIND_LT: hit = !alu_zero && alu_sign;
            KIND_GE: hit = alu_zero || !alu_sign;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
(
    input  logic              br_en,
    input  logic [COND_W-1:0] cond,
    input  logic              alu_zero,
    input  logic              alu_sign,
    output logic              take_branch
);
    br_kind_e kind;
    logic     hit;

    br_kind_decode i_decode (
        .cond (cond),
        .kind (kind)
    );

    br_flag_eval i_eval (
        .kind     (kind),
        .alu_zero (alu_zero),
        .alu_sign (alu_sign),
        .hit      (hit)
    );

    assign take_branch = br_en & hit;

    always_comb begin
        AST_IDLE_WHEN_DISABLED: assert (br_en || !take_branch)
            else $error("taken while disabled"); // R1
        AST_EQ_FOLLOWS_ZERO: assert (!(br_en && cond == 3'b000) || take_branch == alu_zero)
            else $error("eq mismatch"); // R2
        AST_NE_INVERTS_ZERO: assert (!(br_en && cond == 3'b001) || take_branch != alu_zero)
            else $error("ne mismatch"); // R3
        AST_LT_NOT_ON_EQUAL: assert (!(cond == 3'b100 && alu_zero) || !take_branch)
            else $error("lt taken on equal"); // R4
        AST_GE_ON_EQUAL: assert (!(br_en && cond == 3'b101 && alu_zero) || take_branch)
            else $error("ge not taken on equal"); // R5
        AST_UNSUPPORTED_QUIET: assert (!(cond == 3'b010 || cond == 3'b011 || cond[2:1] == 2'b11) || !take_branch)
            else $error("unsupported code taken"); // R6
    end
endmodule

// File: tb/test_br_resolve.sv
`timescale 1ns/1ps
module test_br_resolve;
    logic       clk = 1'b0;
    logic       br_en = 1'b0;
    logic [2:0] cond = 3'b000;
    logic       alu_zero = 1'b0;
    logic       alu_sign = 1'b0;
    logic       take_branch;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    br_resolve i_br_resolve (
        .br_en       (br_en),
        .cond        (cond),
        .alu_zero    (alu_zero),
        .alu_sign    (alu_sign),
        .take_branch (take_branch)
    );

    function automatic bit ref_take(bit en, int code, bit z, bit s);
        if (!en) return 0;               // R1
        case (code)
            0: return z;                 // R2
            1: return !z;                // R3
            4: return z ? 0 : s;         // R4
            5: return z ? 1 : !s;        // R5
            default: return 0;           // R6
        endcase
    endfunction

    function automatic string req_of(bit en, int code);
        if (!en) return "R1";
        case (code)
            0: return "R2";
            1: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply_check(bit en, int code, bit z, bit s);
        bit exp;
        @(posedge clk);
        br_en = en; cond = code[2:0]; alu_zero = z; alu_sign = s;
        @(negedge clk);
        exp = ref_take(en, code, z, s);
        n_checks++;
        if (take_branch !== exp) begin
            n_fail++;
            $display("FAIL %s en=%0b cond=%0d z=%0b s=%0b actual=%0b expected=%0b",
                     req_of(en, code), en, code, z, s, take_branch, exp);
        end
    endtask

    task automatic operand_check(int code, int a, int b);
        logic [31:0] d;
        d = a - b;
        apply_check(1'b1, code, d == 0, d[31]);
    endtask

    initial begin
        // R7: the output must be valid before any clock edge
        #1;
        n_checks++;
        if (take_branch !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 initial actual=%0b expected=0", take_branch);
        end
        // exhaustive sweep covering R1..R6
        for (int e = 0; e < 2; e++)
            for (int c = 0; c < 8; c++)
                for (int z = 0; z < 2; z++)
                    for (int s = 0; s < 2; s++)
                        apply_check(e[0], c, z[0], s[0]);
        // operand-derived flags
        operand_check(0, 7, 7);
        operand_check(1, 7, 7);
        operand_check(4, -3, 5);
        operand_check(4, 5, -3);
        operand_check(4, 9, 9);
        operand_check(5, 9, 9);
        operand_check(5, -1, 0);
        operand_check(5, 0, -1);
        operand_check(0, 100, -100);
        operand_check(1, 0, 1);
        // R7: same-cycle response to a mid-cycle input change
        @(negedge clk);
        br_en = 1'b1; cond = 3'b001; alu_zero = 1'b0; alu_sign = 1'b0;
        #1;
        n_checks++;
        if (take_branch !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 comb actual=%0b expected=1", take_branch);
        end
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule